// File: doc/BRIEF.md
# CCD Vertical Readout Mode Sequencer

This block produces the line-rate vertical control pattern for a four-phase interline CCD. Every decision is taken on a line strobe (`hd_strobe`, one clock wide). Between strobes every output holds its value, so each output level lasts one line period. Readout is organised into readout periods. Each period opens with a one-line vertical sync (`vd`), passes through `VBLANK` blank lines, and then delivers sensor lines in the order set by the active mode.

In frame mode a full image is split into two fields, odd lines first and even lines second. Fast mode is decimated: each period is half a field long, so a full frame takes a quarter of the two-field frame time, and the period delivers only the lines whose number is 2 or 7 modulo 8. In normal operation an electronic shutter drains charge with substrate pulses during the early lines of each period.

A capture request starts a mechanical-shutter sequence. The substrate-bias control goes high and stays high for a programmable lead time counted in lines. One exposure period follows, and its lines are flagged as unusable. Next comes one full sweep period that clears blooming charge. Two frame-mode fields then read the exposed image. After that, normal operation resumes in the selected mode.

Top module: `ccd_vseq`

## Requirements
- R1: `vd` is high for exactly the first line of each readout period, and all outputs change only on clock edges where `hd_strobe` is high. A period lasts `FIELD_HD` lines in frame mode and in every capture phase, and `FIELD_HD/2` lines in fast mode.
- R2: In frame mode, consecutive periods alternate `field_id` between 0 and 1. Lines `VBLANK` onward deliver `line_valid=1`. Field 0 delivers lines 1,3,…,`EFF_LINES-1` and field 1 delivers lines 2,4,…,`EFF_LINES`. When `line_valid=0`, `line_idx` is 0.
- R3: In fast mode (`mode_sel=1`), `field_id` is 0 and the period delivers, in ascending order from line `VBLANK` on, every line in 1..`EFF_LINES` whose number is 2 or 7 modulo 8.
- R4: Transfer gates are one line wide and occur only on the `vd` line. In frame mode, `xfer_gate_a` fires in field 0 and `xfer_gate_b` fires in field 1. In fast mode, both fire in every period.
- R5: A change of `mode_sel` takes effect only at the next period boundary. Entering frame mode from fast mode, or from a capture, starts with field 0.
- R6: In normal operation, `sub_drain_en` is high on the lines of a period whose position is below `shutter_line`. It is never high during any capture phase.
- R7: `sub_bias_ctrl` rises on the first line after a capture request that arrives in normal operation. Exposure starts at the first period boundary reached once the lead counter has counted `LEAD_HD` lines. The bias stays high to the end of the exposure period.
- R8: The exposure period issues no transfer gate. Its delivered lines follow the field-0 pattern and carry `line_bad=1`. `line_bad` is never high outside it.
- R9: The period after exposure is a sweep period. `sweep_en` is high on all of its `FIELD_HD` lines, and it delivers no lines and no gates.
- R10: After the sweep, a frame-mode field 0 with `xfer_gate_a` and a field 1 with `xfer_gate_b` read the image. Normal operation then resumes in the mode given by `mode_sel`.
- R11: A capture request that arrives while a capture sequence is running has no effect.
- R12: After reset, and until the first line strobe, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hd_strobe | input | 1 | One-clock line strobe |
| mode_sel | input | 1 | 0 = two-field frame mode, 1 = fast decimated mode |
| capture_req | input | 1 | Starts a mechanical-shutter capture |
| shutter_line | input | LINE_W | Period position where the drain pulses stop |
| vd | output | 1 | Vertical sync, first line of a period |
| field_id | output | 1 | Field being read (0 or 1) |
| xfer_gate_a | output | 1 | Readout gate for phase group A |
| xfer_gate_b | output | 1 | Readout gate for phase group B |
| sweep_en | output | 1 | High-speed vertical sweep enable |
| sub_bias_ctrl | output | 1 | Substrate-bias control level |
| sub_drain_en | output | 1 | Substrate drain pulse enable |
| line_valid | output | 1 | A sensor line is delivered on this line |
| line_bad | output | 1 | Delivered line contains blooming |
| line_idx | output | LINE_W | Sensor line number being delivered |

## Verification
Some properties are checked on every cycle. Outputs hold still between strobes. Gates appear only on sync lines. A sweep line never carries data or a gate. Drain pulses never coincide with the bias or the sweep. Every bad line sits inside the bias window. Delivered indices stay within the array. Exposure never begins before the bias has been high for the lead count of lines.

Other behaviours need whole scenarios, and a line-accurate model in the bench supplies them. These are the exact line sequences of both fields and of the decimated pattern, field alternation, and the deferral of a mode change to the boundary. The bench also confirms that the full capture ordering runs through exposure, sweep and both read fields, and that repeated requests during a capture are ignored.

// File: rtl/ccd_vseq_pkg.sv
package ccd_vseq_pkg;

  typedef enum logic [2:0] {
    ST_LIVE   = 3'd0,
    ST_LEAD   = 3'd1,
    ST_EXPOSE = 3'd2,
    ST_SWEEP  = 3'd3,
    ST_READ_A = 3'd4,
    ST_READ_B = 3'd5
  } cap_st_e;

  typedef enum logic {
    MD_FRAME = 1'b0,
    MD_FAST  = 1'b1
  } rd_mode_e;

endpackage

// File: rtl/ccd_vseq_timer.sv
module ccd_vseq_timer #(
  parameter int FIELD_HD = 650,
  parameter int FAST_HD  = 325,
  parameter int LINE_W   = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hd_strobe,
  input  logic              fast_period,
  output logic [LINE_W-1:0] pos,
  output logic              period_end
);

  logic [LINE_W-1:0] pos_q, pos_d;
  logic [LINE_W-1:0] last_pos;

  always_comb begin
    last_pos   = fast_period ? LINE_W'(FAST_HD - 1) : LINE_W'(FIELD_HD - 1);
    period_end = (pos_q == last_pos);
    pos_d      = pos_q;
    if (hd_strobe) begin
      pos_d = period_end ? '0 : pos_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
    end else begin
      pos_q <= pos_d;
    end
  end

  assign pos = pos_q;

endmodule

// File: rtl/ccd_vseq_linemap.sv
module ccd_vseq_linemap
  import ccd_vseq_pkg::*;
#(
  parameter int EFF_LINES = 1236,
  parameter int VBLANK    = 12,
  parameter int LINE_W    = 11
) (
  input  rd_mode_e          act_mode,
  input  logic              field_sel,
  input  logic [LINE_W-1:0] pos,
  output logic              hit,
  output logic [LINE_W-1:0] idx
);

  localparam int FLD_LINES  = EFF_LINES / 2;
  localparam int REM8       = EFF_LINES % 8;
  localparam int FAST_LINES = 2 * (EFF_LINES / 8) + ((REM8 >= 2) ? 1 : 0) + ((REM8 >= 7) ? 1 : 0);

  logic [LINE_W-1:0] k;
  logic [LINE_W-1:0] n_lines;
  logic [LINE_W-1:0] frame_idx;
  logic [LINE_W-1:0] fast_idx;

  always_comb begin
    k         = pos - LINE_W'(VBLANK);
    n_lines   = (act_mode == MD_FAST) ? LINE_W'(FAST_LINES) : LINE_W'(FLD_LINES);
    hit       = (pos >= LINE_W'(VBLANK)) && (k < n_lines);
    frame_idx = (k << 1) + LINE_W'(1) + LINE_W'(field_sel);
    fast_idx  = ((k >> 1) << 3) + (k[0] ? LINE_W'(7) : LINE_W'(2));
    idx       = hit ? ((act_mode == MD_FAST) ? fast_idx : frame_idx) : '0;
  end

endmodule

// File: rtl/ccd_vseq_ctrl.sv
module ccd_vseq_ctrl
  import ccd_vseq_pkg::*;
#(
  parameter int LEAD_HD = 200
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     hd_strobe,
  input  logic     period_end,
  input  logic     capture_req,
  input  logic     mode_sel,
  output cap_st_e  cap_st,
  output rd_mode_e act_mode,
  output logic     field_sel
);

  localparam int CW = $clog2(LEAD_HD + 1);

  cap_st_e        st_q, st_d;
  rd_mode_e       mode_q, mode_d;
  logic           fld_q, fld_d;
  logic [CW-1:0]  lead_q, lead_d;
  logic           lead_done;
  rd_mode_e       req_mode;

  always_comb begin
    req_mode  = mode_sel ? MD_FAST : MD_FRAME;
    lead_done = (lead_q >= CW'(LEAD_HD));
    st_d      = st_q;
    mode_d    = mode_q;
    fld_d     = fld_q;
    lead_d    = lead_q;

    if (hd_strobe && (st_q == ST_LEAD) && !lead_done) begin
      lead_d = lead_q + 1'b1;
    end

    if (hd_strobe && period_end) begin
      unique case (st_q)
        ST_LIVE, ST_LEAD: begin
          if ((st_q == ST_LEAD) && lead_done) begin
            st_d   = ST_EXPOSE;
            mode_d = MD_FRAME;
            fld_d  = 1'b0;
          end else begin
            mode_d = req_mode;
            fld_d  = (req_mode == MD_FRAME) && (mode_q == MD_FRAME) && !fld_q;
          end
        end
        ST_EXPOSE: begin
          st_d  = ST_SWEEP;
          fld_d = 1'b0;
        end
        ST_SWEEP: begin
          st_d  = ST_READ_A;
          fld_d = 1'b0;
        end
        ST_READ_A: begin
          st_d  = ST_READ_B;
          fld_d = 1'b1;
        end
        ST_READ_B: begin
          st_d   = ST_LIVE;
          mode_d = req_mode;
          fld_d  = 1'b0;
        end
        default: begin
          st_d   = ST_LIVE;
          mode_d = MD_FRAME;
          fld_d  = 1'b0;
        end
      endcase
    end

    if ((st_q == ST_LIVE) && capture_req) begin
      st_d   = ST_LEAD;
      lead_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_LIVE;
      mode_q <= MD_FRAME;
      fld_q  <= 1'b0;
      lead_q <= '0;
    end else begin
      st_q   <= st_d;
      mode_q <= mode_d;
      fld_q  <= fld_d;
      lead_q <= lead_d;
    end
  end

  assign cap_st    = st_q;
  assign act_mode  = mode_q;
  assign field_sel = fld_q;

endmodule

// File: rtl/ccd_vseq.sv
module ccd_vseq
  import ccd_vseq_pkg::*;
#(
  parameter int EFF_LINES = 1236,
  parameter int FIELD_HD  = 650,
  parameter int VBLANK    = 12,
  parameter int LEAD_HD   = 200,
  parameter int LINE_W    = $clog2(((FIELD_HD > EFF_LINES) ? FIELD_HD : EFF_LINES) + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hd_strobe,
  input  logic              mode_sel,
  input  logic              capture_req,
  input  logic [LINE_W-1:0] shutter_line,
  output logic              vd,
  output logic              field_id,
  output logic              xfer_gate_a,
  output logic              xfer_gate_b,
  output logic              sweep_en,
  output logic              sub_bias_ctrl,
  output logic              sub_drain_en,
  output logic              line_valid,
  output logic              line_bad,
  output logic [LINE_W-1:0] line_idx
);

  localparam int FAST_HD = FIELD_HD / 2;

  cap_st_e           cap_st;
  rd_mode_e          act_mode;
  logic              field_sel;
  logic [LINE_W-1:0] pos;
  logic              period_end;
  logic              map_hit;
  logic [LINE_W-1:0] map_idx;

  ccd_vseq_ctrl #(
    .LEAD_HD (LEAD_HD)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .hd_strobe   (hd_strobe),
    .period_end  (period_end),
    .capture_req (capture_req),
    .mode_sel    (mode_sel),
    .cap_st      (cap_st),
    .act_mode    (act_mode),
    .field_sel   (field_sel)
  );

  ccd_vseq_timer #(
    .FIELD_HD (FIELD_HD),
    .FAST_HD  (FAST_HD),
    .LINE_W   (LINE_W)
  ) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .hd_strobe   (hd_strobe),
    .fast_period (act_mode == MD_FAST),
    .pos         (pos),
    .period_end  (period_end)
  );

  ccd_vseq_linemap #(
    .EFF_LINES (EFF_LINES),
    .VBLANK    (VBLANK),
    .LINE_W    (LINE_W)
  ) u_map (
    .act_mode  (act_mode),
    .field_sel (field_sel),
    .pos       (pos),
    .hit       (map_hit),
    .idx       (map_idx)
  );

  logic              live_like;
  logic              first_line;
  logic              vd_d, fld_d, ga_d, gb_d, sw_d, bias_d, drn_d, lv_d, bad_d;
  logic [LINE_W-1:0] idx_d;

  always_comb begin
    live_like  = (cap_st == ST_LIVE) || (cap_st == ST_LEAD);
    first_line = (pos == '0);
    vd_d   = first_line;
    fld_d  = field_sel;
    ga_d   = first_line && ((live_like && ((act_mode == MD_FAST) || !field_sel)) ||
                            (cap_st == ST_READ_A));
    gb_d   = first_line && ((live_like && ((act_mode == MD_FAST) || field_sel)) ||
                            (cap_st == ST_READ_B));
    sw_d   = (cap_st == ST_SWEEP);
    lv_d   = map_hit && (cap_st != ST_SWEEP);
    idx_d  = lv_d ? map_idx : '0;
    bad_d  = map_hit && (cap_st == ST_EXPOSE);
    bias_d = (cap_st == ST_LEAD) || (cap_st == ST_EXPOSE);
    drn_d  = (cap_st == ST_LIVE) && (pos < shutter_line);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vd            <= 1'b0;
      field_id      <= 1'b0;
      xfer_gate_a   <= 1'b0;
      xfer_gate_b   <= 1'b0;
      sweep_en      <= 1'b0;
      sub_bias_ctrl <= 1'b0;
      sub_drain_en  <= 1'b0;
      line_valid    <= 1'b0;
      line_bad      <= 1'b0;
      line_idx      <= '0;
    end else if (hd_strobe) begin
      vd            <= vd_d;
      field_id      <= fld_d;
      xfer_gate_a   <= ga_d;
      xfer_gate_b   <= gb_d;
      sweep_en      <= sw_d;
      sub_bias_ctrl <= bias_d;
      sub_drain_en  <= drn_d;
      line_valid    <= lv_d;
      line_bad      <= bad_d;
      line_idx      <= idx_d;
    end
  end

endmodule

// File: rtl/ccd_vseq_chk.sv
module ccd_vseq_chk #(
  parameter int EFF_LINES = 1236,
  parameter int LEAD_HD   = 200,
  parameter int LINE_W    = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hd_strobe,
  input logic              vd,
  input logic              field_id,
  input logic              xfer_gate_a,
  input logic              xfer_gate_b,
  input logic              sweep_en,
  input logic              sub_bias_ctrl,
  input logic              sub_drain_en,
  input logic              line_valid,
  input logic              line_bad,
  input logic [LINE_W-1:0] line_idx
);

  localparam int CW = $clog2(LEAD_HD + 2);

  logic [CW-1:0] bias_lines;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bias_lines <= '0;
    end else if (!sub_bias_ctrl) begin
      bias_lines <= '0;
    end else if (hd_strobe && (bias_lines != CW'(LEAD_HD + 1))) begin
      bias_lines <= bias_lines + 1'b1;
    end
  end

  // R1
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hd_strobe |=> $stable({vd, field_id, xfer_gate_a, xfer_gate_b, sweep_en,
                            sub_bias_ctrl, sub_drain_en, line_valid, line_bad, line_idx}));

  // R4
  gate_on_vd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_gate_a || xfer_gate_b) |-> vd);

  // R9
  sweep_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_en |-> (!line_valid && !xfer_gate_a && !xfer_gate_b));

  // R9
  sweep_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sweep_en) |-> vd);

  // R6
  drain_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sub_drain_en |-> (!sub_bias_ctrl && !sweep_en));

  // R8
  bad_in_bias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_bad |-> (sub_bias_ctrl && line_valid && !xfer_gate_a && !xfer_gate_b));

  // R7
  lead_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_bad) |-> (bias_lines >= CW'(LEAD_HD)));

  // R7
  bias_to_sweep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sub_bias_ctrl) |-> sweep_en);

  // R2
  line_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid |-> ((line_idx != '0) && (line_idx <= LINE_W'(EFF_LINES))));

endmodule

bind ccd_vseq ccd_vseq_chk #(
  .EFF_LINES (EFF_LINES),
  .LEAD_HD   (LEAD_HD),
  .LINE_W    (LINE_W)
) u_chk (.*);

// File: tb/tb_ccd_vseq.sv
`timescale 1ns/1ps
module tb_ccd_vseq;

  localparam int EFF   = 30;
  localparam int FLD   = 40;
  localparam int FAST  = FLD / 2;
  localparam int VB    = 3;
  localparam int LEAD  = 25;
  localparam int LW    = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          hd_strobe;
  logic          mode_sel;
  logic          capture_req;
  logic [LW-1:0] shutter_line;
  logic          vd, field_id, xfer_gate_a, xfer_gate_b, sweep_en;
  logic          sub_bias_ctrl, sub_drain_en, line_valid, line_bad;
  logic [LW-1:0] line_idx;

  always #5 clk = ~clk;

  ccd_vseq #(
    .EFF_LINES (EFF),
    .FIELD_HD  (FLD),
    .VBLANK    (VB),
    .LEAD_HD   (LEAD),
    .LINE_W    (LW)
  ) dut (.*);

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  int cyc   = 0;

  int odd_q[$], even_q[$], fast_q[$];

  // reference model state: 0 live, 1 lead, 2 expose, 3 sweep, 4 read A, 5 read B
  int m_st, m_mode, m_field, m_pos, m_cnt;
  int e_vd, e_fld, e_ga, e_gb, e_sw, e_bias, e_drn, e_lv, e_bad, e_idx;
  string t_gate, t_line;
  int kk, per, val;
  bit inwin, lead_ok;

  task automatic check(input string tag, input string nm, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual %0d expected %0d at cycle %0d", tag, nm, act, exp, cyc);
    end
  endtask

  always @(posedge clk) cyc++;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_mode = 0; m_field = 0; m_pos = 0; m_cnt = 0;
      e_vd = 0; e_fld = 0; e_ga = 0; e_gb = 0; e_sw = 0; e_bias = 0;
      e_drn = 0; e_lv = 0; e_bad = 0; e_idx = 0;
      t_gate = "R12"; t_line = "R12";
    end else begin
      if (hd_strobe) begin
        kk = m_pos - VB;
        inwin = 1'b0; val = 0;
        if (m_mode == 1) begin
          if (kk >= 0 && kk < fast_q.size()) begin inwin = 1'b1; val = fast_q[kk]; end
        end else if (m_field == 1) begin
          if (kk >= 0 && kk < even_q.size()) begin inwin = 1'b1; val = even_q[kk]; end
        end else begin
          if (kk >= 0 && kk < odd_q.size()) begin inwin = 1'b1; val = odd_q[kk]; end
        end
        e_vd   = (m_pos == 0);
        e_fld  = m_field;
        e_ga   = (m_pos == 0) && ((m_st <= 1 && (m_mode == 1 || m_field == 0)) || m_st == 4);
        e_gb   = (m_pos == 0) && ((m_st <= 1 && (m_mode == 1 || m_field == 1)) || m_st == 5);
        e_sw   = (m_st == 3);
        e_lv   = inwin && (m_st != 3);
        e_idx  = e_lv ? val : 0;
        e_bad  = inwin && (m_st == 2);
        e_bias = (m_st == 1 || m_st == 2);
        e_drn  = (m_st == 0) && (m_pos < shutter_line);
        t_gate = (m_st >= 4) ? "R10" : "R4";
        t_line = (m_mode == 1) ? "R3" : "R2";
        per     = (m_mode == 1) ? FAST : FLD;
        lead_ok = (m_cnt >= LEAD);
        if (m_st == 1 && !lead_ok) m_cnt++;
        if (m_pos == per - 1) begin
          m_pos = 0;
          // R5: mode and field picked up only here
          case (m_st)
            0, 1: begin
              if (m_st == 1 && lead_ok) begin
                m_st = 2; m_mode = 0; m_field = 0;
              end else begin
                m_field = (mode_sel == 0 && m_mode == 0 && m_field == 0) ? 1 : 0;
                m_mode  = mode_sel;
              end
            end
            2: begin m_st = 3; m_field = 0; end
            3: begin m_st = 4; m_field = 0; end
            4: begin m_st = 5; m_field = 1; end
            default: begin m_st = 0; m_mode = mode_sel; m_field = 0; end
          endcase
        end else begin
          m_pos++;
        end
      end
      // R11: requests outside live operation are dropped
      if (m_st == 0 && capture_req) begin m_st = 1; m_cnt = 0; end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R1",   "vd",            vd,            e_vd);
      check("R2",   "field_id",      field_id,      e_fld);
      check(t_gate, "xfer_gate_a",   xfer_gate_a,   e_ga);
      check(t_gate, "xfer_gate_b",   xfer_gate_b,   e_gb);
      check("R9",   "sweep_en",      sweep_en,      e_sw);
      check("R7",   "sub_bias_ctrl", sub_bias_ctrl, e_bias);
      check("R6",   "sub_drain_en",  sub_drain_en,  e_drn);
      check(t_line, "line_valid",    line_valid,    e_lv);
      check(t_line, "line_idx",      line_idx,      e_idx);
      check("R8",   "line_bad",      line_bad,      e_bad);
    end
  end

  int bad_rises = 0, bias_rises = 0, sweep_clks = 0;
  logic prev_bad = 1'b0, prev_bias = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (line_bad && !prev_bad) bad_rises++;
      if (sub_bias_ctrl && !prev_bias) bias_rises++;
      if (sweep_en) sweep_clks++;
      prev_bad  <= line_bad;
      prev_bias <= sub_bias_ctrl;
    end
  end

  initial begin
    hd_strobe = 1'b0;
    @(posedge rst_n);
    forever begin
      repeat (3) @(negedge clk) hd_strobe = 1'b0;
      @(negedge clk) hd_strobe = 1'b1;
    end
  end

  task automatic pulse_capture();
    @(negedge clk) capture_req = 1'b1;
    @(negedge clk) capture_req = 1'b0;
  endtask

  initial begin
    int t1, t2;
    for (int l = 1; l <= EFF; l++) begin
      if (l % 2 == 1) odd_q.push_back(l); else even_q.push_back(l);
      if (l % 8 == 2 || l % 8 == 7) fast_q.push_back(l);
    end
    rst_n = 1'b0; mode_sel = 1'b0; capture_req = 1'b0; shutter_line = LW'(5);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12: nothing driven before the first line strobe
    check("R12", "outputs after reset",
          {vd, field_id, xfer_gate_a, xfer_gate_b, sweep_en, sub_bias_ctrl,
           sub_drain_en, line_valid, line_bad, 6'(line_idx)}, 0);

    repeat (400) @(negedge clk);
    shutter_line = LW'(12);
    repeat (50) @(negedge clk);
    // R5: switch mid-period, fast periods begin at the boundary
    mode_sel = 1'b1;
    @(posedge vd); @(negedge clk); t1 = cyc;
    @(posedge vd); @(negedge clk); t2 = cyc;
    check("R5", "first fast period length in clocks", t2 - t1, FAST * 4);
    repeat (200) @(negedge clk);
    mode_sel = 1'b0;
    repeat (250) @(negedge clk);

    // capture from frame mode with repeated requests (R11)
    pulse_capture();
    repeat (100) @(negedge clk);
    pulse_capture();
    repeat (200) @(negedge clk);
    pulse_capture();
    repeat (1200) @(negedge clk);
    check("R11", "exposure starts after first capture", bad_rises, 1);
    check("R7",  "bias windows after first capture", bias_rises, 1);

    // capture from fast mode
    mode_sel = 1'b1;
    repeat (300) @(negedge clk);
    pulse_capture();
    repeat (60) @(negedge clk);
    pulse_capture();
    repeat (1400) @(negedge clk);
    check("R11", "exposure starts after second capture", bad_rises, 2);
    check("R9",  "sweep clocks over two captures", sweep_clks, 2 * FLD * 4);
    shutter_line = LW'(0);
    repeat (300) @(negedge clk);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule